// File: doc/BRIEF.md
# Coprocessor Branch Resolver

This block decides where a small coprocessor goes after a branch instruction. Each cycle it takes the 32-bit instruction word, the current word address (PC), one value read from the register file, the value of register zero, and the zero and overflow flags left by the last arithmetic operation. From these it works out whether the branch is taken and what the next PC is. Both results are registered, so they appear one clock edge after the inputs are sampled.

One major opcode covers two branch families. The absolute family jumps to a word address. That address is either carried in the instruction or held in a register. The jump can be unconditional, or it can depend on the zero or overflow flag. The relative family compares register zero against a 16-bit immediate and, when the comparison holds, moves the PC by a signed word offset. The offset is stored as a magnitude plus a separate sign bit. Any instruction that is not a branch, or a branch that is not taken, advances the PC by one word.

The block also brings out the register index named by the instruction. The register file uses this index to return the target value in the same cycle.

Top module: `cbr_branch_resolver`

## Requirements
- R1: An instruction is a branch only when bits [31:28] equal 8 and bits [27:25] equal 0 (absolute) or 1 (relative). Any other word gives taken=0 and next PC = PC+1.
- R2: For an absolute branch with bit 21 = 0, the taken target is the 11-bit word address in bits [12:2].
- R3: For an absolute branch with bit 21 = 1, the taken target is the low 11 bits of the register read value.
- R4: The absolute condition sits in bits [24:22]. Code 0 is always taken, code 1 is taken when the zero flag is 1, code 2 is taken when the overflow flag is 1, and codes 3 to 7 are never taken.
- R5: A relative branch compares R0 with the unsigned immediate in bits [15:0]. With bit 16 = 0 it is taken when R0 < imm. With bit 16 = 1 it is taken when R0 >= imm.
- R6: A taken relative branch targets PC + mag when bit 24 = 0 and PC - mag when bit 24 = 1. Here mag is bits [23:17] in words, and the result wraps modulo 2048.
- R7: When no branch is taken, the next PC is PC+1 modulo 2048 (2047 goes to 0).
- R8: Both outputs are registered and change only on the clock edge that samples the inputs. Synchronous active-low reset clears taken to 0 and next PC to 0.
- R9: The register index output always equals instruction bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word under evaluation |
| pc_i | input | 11 | Word address of that instruction |
| reg_val_i | input | 16 | Register file value for the index on reg_sel_o |
| r0_i | input | 16 | Current value of register zero |
| flag_zero_i | input | 1 | Last arithmetic result was zero |
| flag_ovf_i | input | 1 | Last arithmetic operation overflowed |
| reg_sel_o | output | 2 | Register index for the target read |
| taken_o | output | 1 | Registered branch-taken flag |
| next_pc_o | output | 11 | Registered next word address |

## Verification
Every cycle, the assertions check that non-branch words never show as taken. They check that untaken results land on the previous PC plus one, that undefined condition codes never branch, and that unconditional absolute jumps deliver the immediate or register target. The unsigned comparison edges and sign-magnitude offsets are shown only by the bench's scenarios: equal operands, a maximal R0, negative zero, and both directions of wrap. The flag-gated conditions and the register-index output are also shown only there.

// File: rtl/cbr_pkg.sv
// Package: shared field layout and decoded-instruction type for the
// branch resolver. Assumes the fixed 32-bit instruction format.
package cbr_pkg;
    localparam int INSTR_W  = 32;
    localparam int PC_W     = 11;
    localparam int IMM_W    = 16;
    localparam int MAG_W    = 7;
    localparam int COND_W   = 3;
    localparam int RSEL_W   = 2;

    localparam logic [3:0] OPC_BRANCH = 4'd8;
    localparam logic [2:0] SUB_ABS    = 3'd0;
    localparam logic [2:0] SUB_REL    = 3'd1;

    typedef enum logic [COND_W-1:0] {
        COND_ALWAYS = 3'd0,
        COND_ZERO   = 3'd1,
        COND_OVF    = 3'd2
    } cond_e;

    typedef struct packed {
        logic              is_abs;
        logic              is_rel;
        logic [COND_W-1:0] cond;
        logic              use_reg;
        logic [PC_W-1:0]   abs_addr;
        logic [RSEL_W-1:0] rsel;
        logic              rel_neg;
        logic [MAG_W-1:0]  rel_mag;
        logic              rel_ge;
        logic [IMM_W-1:0]  rel_imm;
    } br_fields_t;
endpackage

// File: rtl/cbr_decode.sv
// Module: splits an instruction word into branch fields.
// Assumes opcode in [31:28], sub-opcode in [27:25]; purely combinational.
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output br_fields_t         fields_o
);
    logic is_br;

    // Extract every field; family flags qualify which ones matter.
    always_comb begin
        is_br             = (instr_i[31:28] == OPC_BRANCH);
        fields_o.is_abs   = is_br && (instr_i[27:25] == SUB_ABS);
        fields_o.is_rel   = is_br && (instr_i[27:25] == SUB_REL);
        fields_o.cond     = instr_i[24:22];
        fields_o.use_reg  = instr_i[21];
        fields_o.abs_addr = instr_i[12:2];
        fields_o.rsel     = instr_i[1:0];
        fields_o.rel_neg  = instr_i[24];
        fields_o.rel_mag  = instr_i[23:17];
        fields_o.rel_ge   = instr_i[16];
        fields_o.rel_imm  = instr_i[15:0];
    end
endmodule

// File: rtl/cbr_abs_eval.sv
// Module: evaluates an absolute branch (condition and target).
// Assumes DATA_W >= PC_W; the register target uses the low PC_W bits.
module cbr_abs_eval
    import cbr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  br_fields_t        fields_i,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic              flag_zero_i,
    input  logic              flag_ovf_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o
);
    // Gate on the condition code; unknown codes never branch.
    always_comb begin
        unique case (fields_i.cond)
            COND_ALWAYS: taken_o = fields_i.is_abs;
            COND_ZERO:   taken_o = fields_i.is_abs && flag_zero_i;
            COND_OVF:    taken_o = fields_i.is_abs && flag_ovf_i;
            default:     taken_o = 1'b0;
        endcase
    end

    // Pick the register-held or immediate target.
    always_comb begin
        target_o = fields_i.use_reg ? reg_val_i[PC_W-1:0] : fields_i.abs_addr;
    end
endmodule

// File: rtl/cbr_rel_eval.sv
// Module: evaluates a relative branch: unsigned compare of R0 with an
// immediate, target from a sign-magnitude word offset (wraps mod 2^PC_W).
module cbr_rel_eval
    import cbr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  br_fields_t        fields_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] r0_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o
);
    localparam int PAD_W = PC_W - MAG_W;

    logic            below;
    logic [PC_W-1:0] mag_ext;

    // Unsigned comparison selects less-than or greater-or-equal.
    always_comb begin
        below   = (r0_i < DATA_W'(fields_i.rel_imm));
        taken_o = fields_i.is_rel && (fields_i.rel_ge ? !below : below);
    end

    // Apply the magnitude in the direction given by the sign bit.
    always_comb begin
        mag_ext  = {{PAD_W{1'b0}}, fields_i.rel_mag};
        target_o = fields_i.rel_neg ? (pc_i - mag_ext) : (pc_i + mag_ext);
    end
endmodule

// File: rtl/cbr_branch_resolver.sv
// Module: top of the branch resolver. Decodes the instruction, runs the
// absolute and relative evaluators, and registers taken / next PC.
// Assumes the register file returns reg_val_i for reg_sel_o in the same cycle.
module cbr_branch_resolver
    import cbr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        instr_i,
    input  logic [10:0]        pc_i,
    input  logic [DATA_W-1:0]  reg_val_i,
    input  logic [DATA_W-1:0]  r0_i,
    input  logic               flag_zero_i,
    input  logic               flag_ovf_i,
    output logic [1:0]         reg_sel_o,
    output logic               taken_o,
    output logic [10:0]        next_pc_o
);
    br_fields_t      fields;
    logic            abs_taken;
    logic            rel_taken;
    logic [PC_W-1:0] abs_target;
    logic [PC_W-1:0] rel_target;
    logic            taken_d;
    logic [PC_W-1:0] next_pc_d;

    cbr_decode u_decode (
        .instr_i  (instr_i),
        .fields_o (fields)
    );

    cbr_abs_eval #(.DATA_W(DATA_W)) u_abs (
        .fields_i    (fields),
        .reg_val_i   (reg_val_i),
        .flag_zero_i (flag_zero_i),
        .flag_ovf_i  (flag_ovf_i),
        .taken_o     (abs_taken),
        .target_o    (abs_target)
    );

    cbr_rel_eval #(.DATA_W(DATA_W)) u_rel (
        .fields_i (fields),
        .pc_i     (pc_i),
        .r0_i     (r0_i),
        .taken_o  (rel_taken),
        .target_o (rel_target)
    );

    // Expose the register index for the same-cycle target read.
    always_comb begin
        reg_sel_o = fields.rsel;
    end

    // Merge the two families; fall through to the sequential address.
    always_comb begin
        taken_d = abs_taken || rel_taken;
        if (abs_taken)      next_pc_d = abs_target;
        else if (rel_taken) next_pc_d = rel_target;
        else                next_pc_d = pc_i + PC_W'(1);
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else begin
            taken_o   <= taken_d;
            next_pc_o <= next_pc_d;
        end
    end

    AST_NONBRANCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[31:28]) != 4'd8) |-> !taken_o); // R1
    AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> next_pc_o == $past(pc_i) + 11'd1); // R7
    AST_RSVD_COND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[31:25]) == 7'b1000_000
         && $past(instr_i[24:22]) > 3'd2) |-> !taken_o); // R4
    AST_IMM_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[31:21]) == 11'b1000_000_000_0)
        |-> (taken_o && next_pc_o == $past(instr_i[12:2]))); // R2
    AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[31:21]) == 11'b1000_000_000_1)
        |-> (taken_o && next_pc_o == $past(reg_val_i[10:0]))); // R3
endmodule

// File: tb/cbr_branch_resolver_tb_top.sv
module cbr_branch_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic [10:0] pc;
    logic [15:0] reg_val;
    logic [15:0] r0;
    logic        fz;
    logic        fo;
    logic [1:0]  reg_sel;
    logic        taken;
    logic [10:0] next_pc;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cbr_branch_resolver dut_i (
        .clk (clk), .rst_n (rst_n), .instr_i (instr), .pc_i (pc),
        .reg_val_i (reg_val), .r0_i (r0), .flag_zero_i (fz), .flag_ovf_i (fo),
        .reg_sel_o (reg_sel), .taken_o (taken), .next_pc_o (next_pc)
    );

    function automatic logic [31:0] abs_ins(input logic [2:0] cond, input logic use_reg,
                                            input logic [10:0] addr, input logic [1:0] rs);
        return {4'd8, 3'd0, cond, use_reg, 8'd0, addr, rs};
    endfunction

    function automatic logic [31:0] rel_ins(input logic neg, input logic [6:0] mag,
                                            input logic ge, input logic [15:0] imm);
        return {4'd8, 3'd1, neg, mag, ge, imm};
    endfunction

    task automatic check(input string req, input logic at, input logic [10:0] ap,
                         input logic et, input logic [10:0] ep);
        total++;
        if (at !== et || ap !== ep) begin
            bad++;
            $display("FAIL %s: taken=%0b pc=%0d expected taken=%0b pc=%0d", req, at, ap, et, ep);
        end
    endtask

    // Drive at a falling edge, capture on the next rising edge, sample at the falling edge after.
    task automatic run(input string req, input logic [31:0] i, input logic [10:0] p,
                       input logic [15:0] rv, input logic [15:0] a0, input logic z, input logic o,
                       input logic et, input logic [10:0] ep);
        @(negedge clk);
        instr = i; pc = p; reg_val = rv; r0 = a0; fz = z; fo = o;
        @(negedge clk);
        check(req, taken, next_pc, et, ep);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        instr = abs_ins(3'd0, 1'b0, 11'd500, 2'd0); pc = 11'd9;
        reg_val = '0; r0 = '0; fz = 1'b0; fo = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset", taken, next_pc, 1'b0, 11'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_nonbranch();
        run("R1 opcode 7", 32'h7000_0001, 11'd100, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 11'd101);
        run("R1 branch sub 3", {4'd8, 3'd3, 25'h0}, 11'd40, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 11'd41);
    endtask

    task automatic t_absolute();
        run("R2 imm target", abs_ins(3'd0, 1'b0, 11'h5A5, 2'd0), 11'd3, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 11'h5A5);
        run("R3 reg target", abs_ins(3'd0, 1'b1, 11'd7, 2'd2), 11'd3, 16'hF123, 16'h0, 1'b0, 1'b0, 1'b1, 11'h123);
        @(negedge clk);
        instr = abs_ins(3'd0, 1'b1, 11'd0, 2'd2);
        #1;
        total++;
        if (reg_sel !== 2'd2) begin
            bad++;
            $display("FAIL R9: reg_sel=%0d expected 2", reg_sel);
        end
    endtask

    task automatic t_conditions();
        run("R4 zero clear", abs_ins(3'd1, 1'b0, 11'd600, 2'd0), 11'd20, 16'h0, 16'h0, 1'b0, 1'b1, 1'b0, 11'd21);
        run("R4 zero set", abs_ins(3'd1, 1'b0, 11'd600, 2'd0), 11'd20, 16'h0, 16'h0, 1'b1, 1'b0, 1'b1, 11'd600);
        run("R4 ovf clear", abs_ins(3'd2, 1'b0, 11'd700, 2'd0), 11'd20, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 11'd21);
        run("R4 ovf set", abs_ins(3'd2, 1'b0, 11'd700, 2'd0), 11'd20, 16'h0, 16'h0, 1'b0, 1'b1, 1'b1, 11'd700);
        run("R4 code 5", abs_ins(3'd5, 1'b0, 11'd700, 2'd0), 11'd20, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 11'd21);
        run("R4 code 3", abs_ins(3'd3, 1'b0, 11'd700, 2'd0), 11'd30, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 11'd31);
    endtask

    task automatic t_compare();
        run("R5 lt taken", rel_ins(1'b0, 7'd5, 1'b0, 16'd11), 11'd100, 16'h0, 16'd10, 1'b0, 1'b0, 1'b1, 11'd105);
        run("R5 lt equal", rel_ins(1'b0, 7'd5, 1'b0, 16'd11), 11'd100, 16'h0, 16'd11, 1'b0, 1'b0, 1'b0, 11'd101);
        run("R5 ge equal", rel_ins(1'b0, 7'd5, 1'b1, 16'd11), 11'd100, 16'h0, 16'd11, 1'b0, 1'b0, 1'b1, 11'd105);
        run("R5 ge unsigned", rel_ins(1'b0, 7'd5, 1'b1, 16'd1), 11'd100, 16'h0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 11'd105);
        run("R5 ge below", rel_ins(1'b0, 7'd5, 1'b1, 16'h8000), 11'd100, 16'h0, 16'h7FFF, 1'b0, 1'b0, 1'b0, 11'd101);
    endtask

    task automatic t_offsets();
        run("R6 plus 127", rel_ins(1'b0, 7'd127, 1'b1, 16'd0), 11'd100, 16'h0, 16'd0, 1'b0, 1'b0, 1'b1, 11'd227);
        run("R6 minus 127 wrap", rel_ins(1'b1, 7'd127, 1'b1, 16'd0), 11'd50, 16'h0, 16'd0, 1'b0, 1'b0, 1'b1, 11'd1971);
        run("R6 plus wrap", rel_ins(1'b0, 7'd20, 1'b1, 16'd0), 11'd2040, 16'h0, 16'd0, 1'b0, 1'b0, 1'b1, 11'd12);
        run("R6 minus zero", rel_ins(1'b1, 7'd0, 1'b1, 16'd0), 11'd77, 16'h0, 16'd0, 1'b0, 1'b0, 1'b1, 11'd77);
    endtask

    task automatic t_fallthru_wrap();
        run("R7 wrap", 32'h0000_0000, 11'd2047, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 11'd0);
    endtask

    task automatic t_latency();
        run("R8 setup", 32'h0, 11'd10, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 11'd11);
        @(negedge clk);
        instr = abs_ins(3'd0, 1'b0, 11'd900, 2'd0);
        #1;
        check("R8 before edge", taken, next_pc, 1'b0, 11'd11);
        @(negedge clk);
        check("R8 after edge", taken, next_pc, 1'b1, 11'd900);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_nonbranch();
                t_absolute();
                t_conditions();
                t_compare();
                t_offsets();
                t_fallthru_wrap();
                t_latency();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule